// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the differential data pair of a low-speed USB link, oversamples it with a free-running system clock of about eleven cycles per bit, and turns each incoming packet into a stream of bytes. The two line inputs are synchronised into the clock domain. A phase counter restarts on every J/K transition, so each bit is sampled near its centre even when the local clock is up to about 1% off. No crystal is needed.

Reception starts when the idle line (J) first moves to K. The receiver then follows the alternating SYNC field until it sees two K bits in a row, and only then starts decoding data. It decodes NRZI, drops the zero that the transmitter inserts after six ones, and assembles bytes least significant bit first. Each byte is presented for one clock. A packet ends cleanly on SE0. It is aborted if the configured buffer space runs out or if a stuffed position does not carry the expected transition. PID, CRC and endpoint handling belong to the logic that consumes the bytes.

Top module: `lsusb_rx`

## Requirements
- R1: Line states are read as {D+, D-}: J = 2'b01 (idle), K = 2'b10, SE0 = 2'b00. Data bits are NRZI-decoded: a sampled state equal to the previous one gives 1, and a change between J and K gives 0.
- R2: A J-to-K edge starts SYNC tracking. Reception of data begins only after two consecutive sampled K bits that follow alternating bits. The SYNC field is sent as the line states K J K J K J K K.
- R3: If two consecutive J samples, an SE0, or eight samples without a double K occur during SYNC tracking, the attempt is dropped without output. The next J-to-K edge starts a new attempt.
- R4: Every J/K transition restarts the bit-phase counter, and a sample is taken CLKS_PER_BIT/2 cycles later or every CLKS_PER_BIT cycles without a transition. Packets whose bit period is within ±1.1% of nominal are received without error.
- R5: Decoded bits are assembled least significant bit first. Each completed byte is shown on rx_byte with rx_byte_vld high for exactly one clock.
- R6: After six consecutive decoded ones, the next bit is a stuffed zero. It is discarded and not counted in the byte. The trailing 1 of SYNC counts as the first of the six.
- R7: A sampled SE0 while receiving data pulses rx_pkt_end for one clock and discards any partial byte. This also applies when the SE0 falls in a stuffed-bit position.
- R8: When a byte completes while BUF_BYTES bytes have already been stored, rx_ovf is set, that byte is not output, rx_pkt_end is not pulsed, and the rest of the packet is ignored until SE0.
- R9: A stuffed position that decodes as 1 sets rx_stuff_err, ends output for that packet without rx_pkt_end, and the rest is ignored until SE0.
- R10: rx_count holds the number of bytes output in the current packet. rx_count, rx_ovf and rx_stuff_err are cleared when the next SYNC completes.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, about CLKS_PER_BIT cycles per bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_byte_vld | output | 1 | One-clock strobe for a received byte |
| rx_byte | output | 8 | Received byte value |
| rx_pkt_end | output | 1 | One-clock pulse on clean end of packet |
| rx_count | output | $clog2(BUF_BYTES+1) | Bytes stored in the current packet |
| rx_ovf | output | 1 | Buffer overflow abort flag |
| rx_stuff_err | output | 1 | Bit-stuff violation abort flag |

## Verification
The assertions assume the line never shows SE1, that every packet is preceded by idle J, and that edges do not land on the sample cycle. Together these keep each sample away from a transition. The bench builds every bit period from a fractional accumulator, so nominal, 1.1% slow and 1.1% fast rates are all realised as mixes of whole clock counts. It drives only J, K and SE0, with a full bit of idle J between packets. Abort cases are made deliberately: an unstuffed run of ones, a ninth byte, and an SE0 placed where a stuffed bit is due.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

  // {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_DRAIN
  } rx_state_t;

  localparam logic [2:0] STUFF_RUN = 3'd6;
  localparam logic [2:0] SYNC_MAX  = 3'd7;

  function automatic logic is_jk(line_t s);
    return (s == LN_J) || (s == LN_K);
  endfunction

  // NRZI: unchanged state -> 1, change -> 0
  function automatic logic nrzi_decode(line_t prev, line_t cur);
    return (prev == cur);
  endfunction

  // LSb-first assembly: new bit enters at the top
  function automatic logic [7:0] shift_in(logic [7:0] sr, logic b);
    return {b, sr[7:1]};
  endfunction

endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       raw,
  output lsrx_pkg::line_t  ln
);
  import lsrx_pkg::*;

  logic [1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= LN_J;
          else        stg[i] <= raw;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= LN_J;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign ln = line_t'(stg[STAGES-1]);

endmodule

// File: rtl/lsrx_dpll.sv
module lsrx_dpll #(
  parameter int CLKS_PER_BIT = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lsrx_pkg::line_t  ln,
  output logic             strobe,
  output logic             k_edge
);
  import lsrx_pkg::*;

  localparam int PH_W = $clog2(CLKS_PER_BIT);
  localparam logic [PH_W-1:0] PH_MAX  = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(CLKS_PER_BIT / 2);

  line_t           ln_q;
  logic [PH_W-1:0] phase;
  logic            jk_edge;

  assign jk_edge = is_jk(ln) && is_jk(ln_q) && (ln != ln_q);
  assign k_edge  = jk_edge && (ln == LN_K);
  assign strobe  = (phase == PH_HALF) && !jk_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ln_q  <= LN_J;
      phase <= '0;
    end else begin
      ln_q <= ln;
      if (jk_edge)              phase <= '0;
      else if (phase == PH_MAX) phase <= '0;
      else                      phase <= phase + 1'b1;
    end

  // R4: a sample is never taken in the cycle right after a re-centring edge
  AST_RECENTRE: assert property (@(posedge clk) disable iff (!rst_n)
    jk_edge |=> !strobe); // R4

endmodule

// File: rtl/lsrx_ctrl.sv
module lsrx_ctrl #(
  parameter int BUF_BYTES = 8,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lsrx_pkg::line_t  ln,
  input  logic             strobe,
  input  logic             k_edge,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic             pkt_end,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             stuff_flag
);
  import lsrx_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_BYTES);

  rx_state_t  state;
  line_t      prev_ln;
  logic [2:0] ones;
  logic [2:0] bitn;
  logic [2:0] sync_n;
  logic       last_k;
  logic [7:0] sr;

  // named events
  logic d_bit, in_data, samp_jk, stuff_slot, data_bit, byte_done, ovf_hit, lock;
  assign d_bit      = nrzi_decode(prev_ln, ln);
  assign in_data    = (state == ST_DATA) && strobe;
  assign samp_jk    = is_jk(ln);
  assign stuff_slot = in_data && samp_jk && (ones == STUFF_RUN);
  assign data_bit   = in_data && samp_jk && (ones != STUFF_RUN);
  assign byte_done  = data_bit && (bitn == 3'd7);
  assign ovf_hit    = byte_done && (count == FULL);
  assign lock       = (state == ST_SYNC) && strobe && (ln == LN_K) && last_k;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= ST_IDLE;
      prev_ln    <= LN_J;
      ones       <= '0;
      bitn       <= '0;
      sync_n     <= '0;
      last_k     <= 1'b0;
      sr         <= '0;
      byte_vld   <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
      count      <= '0;
      ovf_flag   <= 1'b0;
      stuff_flag <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      pkt_end  <= 1'b0;
      case (state)
        ST_IDLE: if (k_edge) begin
          state  <= ST_SYNC;
          last_k <= 1'b0;
          sync_n <= '0;
        end
        ST_SYNC: if (strobe) begin
          if (lock) begin
            state      <= ST_DATA;
            prev_ln    <= LN_K;
            ones       <= 3'd1;
            bitn       <= '0;
            count      <= '0;
            ovf_flag   <= 1'b0;
            stuff_flag <= 1'b0;
          end else if (sync_n == SYNC_MAX || !samp_jk || (ln == LN_J && !last_k)) begin
            state <= ST_IDLE;
          end else begin
            last_k <= (ln == LN_K);
            sync_n <= sync_n + 3'd1;
          end
        end
        ST_DATA: if (strobe) begin
          if (ln == LN_SE0) begin
            pkt_end <= 1'b1;
            state   <= ST_IDLE;
          end else if (!samp_jk) begin
            state <= ST_DRAIN;
          end else begin
            prev_ln <= ln;
            if (stuff_slot) begin
              if (d_bit) begin
                stuff_flag <= 1'b1;
                state      <= ST_DRAIN;
              end else begin
                ones <= '0;
              end
            end else begin
              sr   <= shift_in(sr, d_bit);
              ones <= d_bit ? ones + 3'd1 : 3'd0;
              bitn <= bitn + 3'd1;
              if (ovf_hit) begin
                ovf_flag <= 1'b1;
                state    <= ST_DRAIN;
              end else if (byte_done) begin
                byte_vld  <= 1'b1;
                byte_data <= shift_in(sr, d_bit);
                count     <= count + 1'b1;
              end
            end
          end
        end
        ST_DRAIN: if (strobe && ln == LN_SE0) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end

  AST_LOCK_DOUBLE_K: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_SYNC) |-> $past(ln == LN_K)); // R2
  AST_STUFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_slot |=> !byte_vld); // R6
  AST_END_ON_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> $past(ln == LN_SE0)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> (count != '0) && (count <= FULL)); // R8
  AST_ABORT_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> !ovf_flag && !stuff_flag); // R9

endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx #(
  parameter int CLKS_PER_BIT = 11,
  parameter int BUF_BYTES    = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int CNT_W       = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_dp,
  input  logic             usb_dm,
  output logic             rx_byte_vld,
  output logic [7:0]       rx_byte,
  output logic             rx_pkt_end,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_ovf,
  output logic             rx_stuff_err
);
  import lsrx_pkg::*;

  line_t ln;
  logic  strobe, k_edge;

  lsrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({usb_dp, usb_dm}), .ln(ln)
  );

  lsrx_dpll #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_dpll (
    .clk(clk), .rst_n(rst_n), .ln(ln), .strobe(strobe), .k_edge(k_edge)
  );

  lsrx_ctrl #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ln(ln), .strobe(strobe), .k_edge(k_edge),
    .byte_vld(rx_byte_vld), .byte_data(rx_byte), .pkt_end(rx_pkt_end),
    .count(rx_count), .ovf_flag(rx_ovf), .stuff_flag(rx_stuff_err)
  );

endmodule

// File: tb/lsusb_rx_test.sv
`timescale 1ns/1ps
module lsusb_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, usb_dp = 1'b0, usb_dm = 1'b1;
  logic rx_byte_vld, rx_pkt_end, rx_ovf, rx_stuff_err;
  logic [7:0] rx_byte;
  logic [3:0] rx_count;

  lsusb_rx uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int acc = 0;
  logic [7:0] tx [16];
  int tx_len;
  logic [7:0] rx [16];
  int rx_n = 0, ends = 0;

  always @(negedge clk) if (rst_n) begin
    if (rx_byte_vld) begin if (rx_n < 16) rx[rx_n] = rx_byte; rx_n++; end
    if (rx_pkt_end) ends++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic line(logic [1:0] s, int rate);
    int n;
    acc += rate; n = acc / 100; acc -= n * 100;
    {usb_dp, usb_dm} = s;
    repeat (n) @(negedge clk);
  endtask

  // J=01 K=10 SE0=00
  task automatic send(int rate, bit stuff);
    logic [1:0] cur; int ones;
    line(2'b01, rate);
    for (int i = 0; i < 8; i++) line((i == 7 || i % 2 == 0) ? 2'b10 : 2'b01, rate);
    cur = 2'b10; ones = 1;
    for (int b = 0; b < tx_len; b++)
      for (int i = 0; i < 8; i++) begin
        if (stuff && ones == 6) begin cur = ~cur; line(cur, rate); ones = 0; end
        if (tx[b][i]) ones++; else begin cur = ~cur; ones = 0; end
        line(cur, rate);
      end
    line(2'b00, rate); line(2'b00, rate);
    for (int i = 0; i < 4; i++) line(2'b01, rate);
  endtask

  task automatic clear_rx; rx_n = 0; ends = 0; endtask

  task automatic expect_ok(string req);
    chk(rx_n == tx_len, req, rx_n, tx_len);
    for (int i = 0; i < tx_len && i < rx_n; i++) chk(rx[i] == tx[i], req, rx[i], tx[i]);
    chk(ends == 1, req, ends, 1);
    chk(rx_count == 4'(tx_len), {req, " R10 count"}, rx_count, tx_len);
    chk(!rx_ovf && !rx_stuff_err, {req, " flags"}, {rx_ovf, rx_stuff_err}, 0);
  endtask

  task automatic t_reset;
    chk(!rx_byte_vld && !rx_pkt_end && rx_count == 0 && !rx_ovf && !rx_stuff_err,
        "R11 reset", {rx_count, rx_ovf, rx_stuff_err}, 0);
  endtask

  task automatic t_basic;
    clear_rx; tx_len = 3; tx[0] = 8'hC3; tx[1] = 8'h5A; tx[2] = 8'h01;
    send(1100, 1); expect_ok("R1 R2 R5 basic");
  endtask

  task automatic t_stuff;
    clear_rx; tx_len = 3; tx[0] = 8'hFF; tx[1] = 8'hFF; tx[2] = 8'h80;
    send(1100, 1); expect_ok("R6 unstuff");
  endtask

  task automatic t_drift(int rate, string req);
    clear_rx; tx_len = 8;
    for (int i = 0; i < 8; i++) tx[i] = 8'(8'hF0 ^ (i * 37));
    tx[3] = 8'hFF; tx[4] = 8'h7F;
    send(rate, 1); expect_ok(req);
  endtask

  task automatic t_false_start;
    clear_rx;
    line(2'b10, 1100);
    for (int i = 0; i < 4; i++) line(2'b01, 1100);
    chk(rx_n == 0 && ends == 0, "R3 abandon", rx_n + ends, 0);
    clear_rx; tx_len = 2; tx[0] = 8'h2D; tx[1] = 8'h00;
    send(1100, 1); expect_ok("R3 after abandon");
  endtask

  task automatic t_stuff_err;
    clear_rx; tx_len = 2; tx[0] = 8'hFF; tx[1] = 8'hFF;
    send(1100, 0);
    chk(rx_stuff_err, "R9 stuff err flag", rx_stuff_err, 1);
    chk(rx_n == 0 && ends == 0, "R9 no output", rx_n + ends, 0);
  endtask

  task automatic t_overflow;
    clear_rx; tx_len = 9;
    for (int i = 0; i < 9; i++) tx[i] = 8'(i + 8'h11);
    send(1100, 1);
    chk(rx_ovf, "R8 ovf flag", rx_ovf, 1);
    chk(rx_n == 8, "R8 stored", rx_n, 8);
    chk(ends == 0, "R8 no end", ends, 0);
    chk(rx_count == 8, "R8 R10 count", rx_count, 8);
  endtask

  task automatic t_se0_stuff;
    // 0xFC ends with six ones: SE0 takes the stuffed position
    clear_rx; tx_len = 1; tx[0] = 8'hFC;
    send(1100, 1); expect_ok("R7 se0 in stuff slot");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    t_reset;
    t_basic;
    t_stuff;
    t_drift(1100, "R4 nominal");
    t_drift(1112, "R4 slow clock");
    t_drift(1088, "R4 fast clock");
    t_false_start;
    t_stuff_err;
    t_overflow;
    t_basic;
    t_se0_stuff;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule